// File: doc/BRIEF.md
# Triple Compare Timer

This block holds three independent 32-bit timers behind a small register port. Each timer owns a counter, a reload value and two compare values. It counts up or down, on every clock or only on cycles where the external tick strobe is high. When the counter wraps past its end value it reloads from its reload register and raises an overflow event. When the counter steps onto either compare value it raises a match event. The three timers produce nine event bits. These are held in a shared sticky status register and are combined through a mask register into a single interrupt line.

Software reaches every register through a single-cycle port. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. The port has no flow control, and every access completes in the cycle it is presented. A periodic tick of P counts comes from loading both the counter and the reload register with 0xFFFFFFFF - (P - 1) and counting up. A reload of zero with interrupts masked gives a free-running counter.

Top module: `tri_cmp_timer`

## Requirements
- R1: After reset every counter, reload, compare, control, status and mask register reads zero, and `irq_o` is low.
- R2: Addresses are byte addresses and only word-aligned addresses decode. Timer n (0..2) has counter at 0x10n+0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Control keeps bits 11:0 and mask keeps bits 8:0. Unused bits read zero, and misaligned or unmapped addresses read zero and ignore writes.
- R3: Control bit 3n enables timer n. An enabled timer with direction bit 9+n set adds one per count strobe. A disabled timer holds its count, and re-enabling resumes from that value.
- R4: With direction bit 9+n clear, an enabled timer subtracts one per count strobe.
- R5: Control bit 3n+1 set makes timer n count only on cycles where `ext_tick` is high. With the bit clear it counts on every clock.
- R6: Status bit 3n (compare A) or 3n+1 (compare B) is set at the edge where a count strobe moves the counter onto the matching compare value.
- R7: Counting up from 0xFFFFFFFF, the counter loads the reload value and status bit 3n+2 is set. A reload of 0xFFFFFFFF-(P-1) therefore overflows every P strobes.
- R8: Counting down from 0, the counter loads the reload value and status bit 3n+2 is set.
- R9: Status bits stay set until software writes 1 to them at 0x34. Writing 0 has no effect. An event on the same edge as its clear leaves the bit set.
- R10: `irq_o` is the OR of status bits whose mask bit is 1. An overflow bit 3n+2 counts only while control bit 3n+2 is also 1.
- R11: A counter write replaces the count at that edge, even while the timer runs, and raises no event that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_tick | input | 1 | External count strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench drives each wrap edge directly. A design that reloaded one count late, or tested the wrong end value when counting down, would show an overflow period of P+1 or a stray event at zero. It clears a status bit on the very edge where the overflow recurs. A design that lets the clear win would lose that interrupt. It writes a running counter, which catches a design that increments the written value or fires a match from the discarded count. It also sets an overflow mask bit while the per-timer overflow enable is off, which catches interrupt gating that ignores the control register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_RLD  = 2'd1,
    REG_CMPA = 2'd2,
    REG_CMPB = 2'd3
  } tmr_reg_e;

  typedef struct packed {
    logic ovf;
    logic cmpb;
    logic cmpa;
  } tmr_evt_t;

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel (
  input  logic en_i,
  input  logic use_ext_i,
  input  logic ext_tick_i,
  output logic strobe_o
);

  always_comb begin
    if (use_ext_i) strobe_o = en_i & ext_tick_i;
    else           strobe_o = en_i;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             use_ext_i,
  input  logic             ext_tick_i,
  input  logic             wr_en_i,
  input  tmr_reg_e         wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [CNT_W-1:0] cmpa_o,
  output logic [CNT_W-1:0] cmpb_o,
  output tmr_evt_t         evt_o
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

  logic [CNT_W-1:0] cnt_q, rld_q, cmpa_q, cmpb_q, cnt_nxt;
  logic             strobe, wr_cnt, at_end, adv;

  tmr_tick_sel u_tick (
    .en_i       (en_i),
    .use_ext_i  (use_ext_i),
    .ext_tick_i (ext_tick_i),
    .strobe_o   (strobe)
  );

  assign wr_cnt = wr_en_i && (wr_sel_i == REG_CNT);
  assign adv    = strobe && !wr_cnt;

  always_comb begin
    if (up_i) begin
      at_end  = (cnt_q == TOP);
      cnt_nxt = at_end ? rld_q : cnt_q + ONE;
    end else begin
      at_end  = (cnt_q == ZERO);
      cnt_nxt = at_end ? rld_q : cnt_q - ONE;
    end
  end

  always_comb begin
    evt_o.ovf  = adv && at_end;
    evt_o.cmpa = adv && (cnt_nxt == cmpa_q);
    evt_o.cmpb = adv && (cnt_nxt == cmpb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (wr_cnt) begin
      cnt_q <= wr_data_i;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q  <= ZERO;
      cmpa_q <= ZERO;
      cmpb_q <= ZERO;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        REG_RLD:  rld_q  <= wr_data_i;
        REG_CMPA: cmpa_q <= wr_data_i;
        REG_CMPB: cmpb_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign cmpa_o = cmpa_q;
  assign cmpb_o = cmpb_q;

  // R3: no strobe and no write leaves the count untouched
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !wr_cnt) |=> $stable(cnt_q));

  // R3: up step adds one away from the wrap point
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wr_cnt && up_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + ONE));

  // R4: down step subtracts one away from the wrap point
  p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !wr_cnt && !up_i && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

  // R7: an overflow leaves the reload value in the counter
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.ovf |=> (cnt_q == $past(rld_q)));

  // R11: a counter write lands unchanged
  p_wr_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data_i)));

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int N_TMR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3*N_TMR-1:0] evt_i,
  input  logic               clr_we_i,
  input  logic               mask_we_i,
  input  logic [3*N_TMR-1:0] wdata_i,
  input  logic [N_TMR-1:0]   ovf_ie_i,
  output logic [3*N_TMR-1:0] status_o,
  output logic [3*N_TMR-1:0] mask_o,
  output logic               irq_o
);

  localparam int EVT_W = 3 * N_TMR;

  logic [EVT_W-1:0] status_q, mask_q, gate, clr_vec;

  for (genvar g = 0; g < N_TMR; g++) begin : g_gate
    assign gate[3*g]   = 1'b1;
    assign gate[3*g+1] = 1'b1;
    assign gate[3*g+2] = ovf_ie_i[g];
  end

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | evt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= wdata_i;
    end
  end

  assign irq_o    = |(status_q & mask_q & gate);
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R9: bits not written with 1 stay set
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));

  // R6: every event is recorded, even when cleared on the same edge
  p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R10: with nothing unmasked the line stays low
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/tri_cmp_timer.sv
module tri_cmp_timer
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_tick,
  output logic              irq_o
);

  localparam int EVT_W  = 3 * N_TMR;
  localparam int CTRL_W = 4 * N_TMR;
  localparam int IDX_W  = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_TMR * 16);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_TMR * 16 + 4);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_TMR * 16 + 8);

  logic [CTRL_W-1:0]             ctrl_q;
  logic [N_TMR-1:0][CNT_W-1:0]   cnt_a, rld_a, cmpa_a, cmpb_a;
  logic [N_TMR-1:0]              ovf_ie;
  logic [EVT_W-1:0]              evt_vec, status, mask;
  logic                          aligned, ctrl_we, stat_we, mask_we;
  tmr_reg_e                      reg_sel;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign reg_sel = tmr_reg_e'(bus_addr[3:2]);
  assign ctrl_we = bus_we && (bus_addr == CTRL_ADDR);
  assign stat_we = bus_we && (bus_addr == STAT_ADDR);
  assign mask_we = bus_we && (bus_addr == MASK_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    tmr_evt_t evt;
    logic     sel;

    assign sel       = aligned && (bus_addr[ADDR_W-1:4] == IDX_W'(g));
    assign ovf_ie[g] = ctrl_q[3*g+2];

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (ctrl_q[3*g]),
      .up_i       (ctrl_q[3*N_TMR+g]),
      .use_ext_i  (ctrl_q[3*g+1]),
      .ext_tick_i (ext_tick),
      .wr_en_i    (bus_we && sel),
      .wr_sel_i   (reg_sel),
      .wr_data_i  (bus_wdata),
      .cnt_o      (cnt_a[g]),
      .rld_o      (rld_a[g]),
      .cmpa_o     (cmpa_a[g]),
      .cmpb_o     (cmpb_a[g]),
      .evt_o      (evt)
    );

    assign evt_vec[3*g]   = evt.cmpa;
    assign evt_vec[3*g+1] = evt.cmpb;
    assign evt_vec[3*g+2] = evt.ovf;
  end

  tmr_irq_ctrl #(.N_TMR(N_TMR)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_vec),
    .clr_we_i  (stat_we),
    .mask_we_i (mask_we),
    .wdata_i   (bus_wdata[EVT_W-1:0]),
    .ovf_ie_i  (ovf_ie),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) begin
      bus_rdata = CNT_W'(ctrl_q);
    end else if (bus_addr == STAT_ADDR) begin
      bus_rdata = CNT_W'(status);
    end else if (bus_addr == MASK_ADDR) begin
      bus_rdata = CNT_W'(mask);
    end else if (aligned) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (bus_addr[ADDR_W-1:4] == IDX_W'(i)) begin
          case (reg_sel)
            REG_CNT:  bus_rdata = cnt_a[i];
            REG_RLD:  bus_rdata = rld_a[i];
            REG_CMPA: bus_rdata = cmpa_a[i];
            REG_CMPB: bus_rdata = cmpb_a[i];
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  // R2: a control write is visible from the next edge
  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));

  // R2: a write elsewhere leaves control alone
  p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));

endmodule

// File: tb/tri_cmp_timer_bench.sv
module tri_cmp_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic        irq_o;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tri_cmp_timer u_tri_cmp_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_tick  (ext_tick),
    .irq_o     (irq_o)
  );

  // behavioural reference
  logic [31:0] m_cnt [3];
  logic [31:0] m_rld [3];
  logic [31:0] m_ca  [3];
  logic [31:0] m_cb  [3];
  logic [11:0] m_ctrl;
  logic [8:0]  m_stat, m_mask, m_ev;
  logic [31:0] m_nx;
  logic        m_stb, m_wrc;

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    if (a == 6'h30) return {20'd0, m_ctrl};
    if (a == 6'h34) return {23'd0, m_stat};
    if (a == 6'h38) return {23'd0, m_mask};
    if (a[1:0] != 2'b00 || a[5:4] == 2'd3) return 32'd0;
    case (a[3:2])
      2'd0: return m_cnt[a[5:4]];
      2'd1: return m_rld[a[5:4]];
      2'd2: return m_ca[a[5:4]];
      default: return m_cb[a[5:4]];
    endcase
  endfunction

  function automatic logic model_irq();
    logic r = 1'b0;
    for (int n = 0; n < 3; n++) begin
      r |= m_stat[3*n] & m_mask[3*n];
      r |= m_stat[3*n+1] & m_mask[3*n+1];
      r |= m_stat[3*n+2] & m_mask[3*n+2] & m_ctrl[3*n+2];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < 3; n++) begin
        m_cnt[n] = '0; m_rld[n] = '0; m_ca[n] = '0; m_cb[n] = '0;
      end
      m_ctrl = '0; m_stat = '0; m_mask = '0;
    end else begin
      m_ev = '0;
      for (int n = 0; n < 3; n++) begin
        m_stb = m_ctrl[3*n] && (m_ctrl[3*n+1] ? ext_tick : 1'b1);
        m_wrc = bus_we && (bus_addr == 6'(n * 16));
        if (m_stb && !m_wrc) begin
          if (m_ctrl[9+n]) begin
            if (m_cnt[n] == 32'hFFFF_FFFF) begin m_ev[3*n+2] = 1'b1; m_nx = m_rld[n]; end
            else m_nx = m_cnt[n] + 32'd1;
          end else begin
            if (m_cnt[n] == 32'd0) begin m_ev[3*n+2] = 1'b1; m_nx = m_rld[n]; end
            else m_nx = m_cnt[n] - 32'd1;
          end
          if (m_nx == m_ca[n]) m_ev[3*n] = 1'b1;
          if (m_nx == m_cb[n]) m_ev[3*n+1] = 1'b1;
          m_cnt[n] = m_nx;
        end
      end
      if (bus_we && bus_addr == 6'h34) m_stat = (m_stat & ~bus_wdata[8:0]) | m_ev;
      else m_stat = m_stat | m_ev;
      if (bus_we) begin
        if (bus_addr == 6'h30) m_ctrl = bus_wdata[11:0];
        else if (bus_addr == 6'h38) m_mask = bus_wdata[8:0];
        else if (bus_addr[1:0] == 2'b00 && bus_addr[5:4] != 2'd3) begin
          case (bus_addr[3:2])
            2'd0: m_cnt[bus_addr[5:4]] = bus_wdata;
            2'd1: m_rld[bus_addr[5:4]] = bus_wdata;
            2'd2: m_ca[bus_addr[5:4]]  = bus_wdata;
            default: m_cb[bus_addr[5:4]] = bus_wdata;
          endcase
        end
      end
    end
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (bus_rdata !== model_rd(bus_addr)) begin
        fails++;
        $display("FAIL %s model rdata @%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, model_rd(bus_addr));
      end
      checks++;
      if (irq_o !== model_irq()) begin
        fails++;
        $display("FAIL %s model irq actual=%0b expected=%0b", cur_req, irq_o, model_irq());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_addr = 6'h00;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a;
    #10 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_tick();
    @(posedge clk); #2 ext_tick = 1'b1;
    @(posedge clk); #2 ext_tick = 1'b0;
  endtask

  task automatic irq_at_next(output logic v);
    @(posedge clk); #12 v = irq_o;
  endtask

  initial begin
    logic [31:0] v, v2;
    logic        q;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cmp_on = 1;

    cur_req = "R1";
    for (int a = 0; a < 60; a += 4) begin
      rd(6'(a), v);
      chk("R1 reset value", v, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);

    cur_req = "R2";
    wr(6'h04, 32'h1234_5678); rd(6'h04, v); chk("R2 reload0", v, 32'h1234_5678);
    wr(6'h28, 32'hAAAA_0000); rd(6'h28, v); chk("R2 cmpA2", v, 32'hAAAA_0000);
    wr(6'h2C, 32'h0000_5555); rd(6'h2C, v); chk("R2 cmpB2", v, 32'h0000_5555);
    wr(6'h38, 32'hFFFF_FFFF); rd(6'h38, v); chk("R2 mask width", v, 32'h1FF);
    wr(6'h38, 32'h0);
    wr(6'h30, 32'hFFFF_F000); rd(6'h30, v); chk("R2 ctrl width", v, 32'h0);
    wr(6'h05, 32'hDEAD_BEEF); rd(6'h04, v); chk("R2 misaligned write ignored", v, 32'h1234_5678);
    rd(6'h05, v); chk("R2 misaligned read zero", v, 32'h0);

    cur_req = "R3";
    wr(6'h00, 32'd0);
    wr(6'h30, 32'h201);
    idle(3); rd(6'h00, v); chk("R3 up count", v, 32'd4);
    wr(6'h30, 32'h000);
    rd(6'h00, v); idle(3); rd(6'h00, v2); chk("R3 hold when disabled", v2, v);
    wr(6'h30, 32'h201); rd(6'h00, v2); chk("R3 resume from held value", v2, v + 32'd1);
    wr(6'h30, 32'h000);

    cur_req = "R4";
    wr(6'h14, 32'd10); wr(6'h10, 32'd2);
    wr(6'h30, 32'h008);
    idle(3); rd(6'h10, v); chk("R4 down count through reload", v, 32'd9);
    cur_req = "R8";
    rd(6'h34, v); chk("R8 down overflow status bit5", v & 32'h20, 32'h20);
    wr(6'h30, 32'h000);

    cur_req = "R5";
    wr(6'h20, 32'd0);
    wr(6'h30, 32'h8C0);
    idle(4); pulse_tick(); idle(2); pulse_tick(); pulse_tick(); idle(3);
    rd(6'h20, v); chk("R5 counts only ext ticks", v, 32'd3);
    wr(6'h30, 32'h000);

    cur_req = "R6";
    wr(6'h34, 32'h1FF);
    wr(6'h00, 32'd0); wr(6'h08, 32'd4); wr(6'h0C, 32'd7);
    wr(6'h30, 32'h201);
    idle(3); rd(6'h34, v); chk("R6 compare A match", v & 32'h3, 32'h1);
    idle(2); rd(6'h34, v); chk("R6 compare B match", v & 32'h3, 32'h3);
    wr(6'h30, 32'h000);

    cur_req = "R7";
    wr(6'h34, 32'h1FF);
    wr(6'h04, 32'hFFFF_FFFB); wr(6'h00, 32'hFFFF_FFFB);
    wr(6'h30, 32'h201);
    idle(3); rd(6'h34, v); chk("R7 no overflow before period", v & 32'h4, 32'h0);
    rd(6'h34, v); chk("R7 overflow at period", v & 32'h4, 32'h4);
    wr(6'h34, 32'h004);
    idle(1); rd(6'h34, v); chk("R7 second period not early", v & 32'h4, 32'h0);
    rd(6'h34, v); chk("R7 second overflow after 5", v & 32'h4, 32'h4);
    wr(6'h30, 32'h000);

    cur_req = "R9";
    wr(6'h34, 32'h000); rd(6'h34, v); chk("R9 write 0 keeps bit", v & 32'h4, 32'h4);
    wr(6'h34, 32'h001); rd(6'h34, v); chk("R9 other bit write keeps", v & 32'h4, 32'h4);
    wr(6'h34, 32'h004); rd(6'h34, v); chk("R9 write 1 clears", v & 32'h4, 32'h0);
    wr(6'h00, 32'hFFFF_FFFE);
    wr(6'h30, 32'h201);
    wr(6'h34, 32'h004);
    rd(6'h34, v); chk("R9 set beats same-edge clear", v & 32'h4, 32'h4);
    wr(6'h30, 32'h000);

    cur_req = "R10";
    wr(6'h34, 32'h1FB);
    wr(6'h38, 32'h004); irq_at_next(q); chk("R10 ovf gated by ctrl", {31'd0, q}, 32'd0);
    wr(6'h30, 32'h004); irq_at_next(q); chk("R10 ovf enabled raises irq", {31'd0, q}, 32'd1);
    wr(6'h34, 32'h1FF); irq_at_next(q); chk("R10 cleared drops irq", {31'd0, q}, 32'd0);
    wr(6'h38, 32'h001); wr(6'h00, 32'd2);
    wr(6'h30, 32'h201);
    idle(2); irq_at_next(q); chk("R10 match irq without ovf enable", {31'd0, q}, 32'd1);
    wr(6'h30, 32'h000); wr(6'h38, 32'h000); wr(6'h34, 32'h1FF);

    cur_req = "R11";
    wr(6'h30, 32'h201);
    wr(6'h00, 32'h100);
    rd(6'h00, v); chk("R11 running counter overwritten", v, 32'h101);
    wr(6'h30, 32'h000);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule